// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the memory traffic that starts an exception handler. When the surrounding core accepts an interrupt or a trap, it pulses a start strobe with the exception number and presents its current program counter and condition code byte. The sequencer keeps its own stack pointer. It saves both values on a descending stack and raises the interrupt-mask bits. A control input selects whether one or two mask bits are set. It then reads the handler address from a vector table and presents it as the new program counter, with a one-cycle done strobe.

When reset is released, the sequencer runs a shortened form of the same sequence. It saves nothing, reads the start address from the reset vector slot, and forces the main mask bit. An interrupt-block output stays high through reset, through this start-up fetch, and for a few cycles after it.

All memory traffic uses one synchronous port with a request/ready handshake. Widths, the vector entry size, the mask bit positions, the initial stack pointer and the post-reset block window are all parameters.

Top module: `exc_entry_seq`

## Requirements
- R1: An accepted start produces exactly two writes, in this order. The first writes the program counter to SP-STEP. The second writes the condition code byte, zero-extended, to SP-2*STEP. STEP is ADDR_W/8 bytes (2 by default). sp_out ends at SP-2*STEP.
- R2: With user_en=1, ccr_out after the sequence equals the sampled ccr_in with only the main mask bit (bit I_BIT, default 7) additionally set.
- R3: With user_en=0, ccr_out after the sequence equals the sampled ccr_in with both the main mask bit (bit 7) and the user mask bit (bit UI_BIT, default 6) set.
- R4: After stacking, the block reads address exc_num*VEC_BYTES (VEC_BYTES = 2 by default) and loads the word read into pc_out.
- R5: While mem_req is high and mem_ready is low, mem_req, mem_addr, mem_we and mem_wdata hold their values. The sequence advances only on a cycle with both mem_req and mem_ready high.
- R6: done is high for exactly one cycle, in the first cycle in which pc_out shows the new handler address. busy is low in that cycle.
- R7: After reset is released, the block reads address RST_VEC_NUM*VEC_BYTES (0 by default) into pc_out and makes no write. While reset is held, sp_out equals SP_INIT, ccr_out has only bit 7 set, and mem_req and done are low.
- R8: irq_block is high while reset is held and during the start-up fetch. It stays high for HOLD_CYC cycles (default 2), counted from and including the done cycle of that fetch, and is then low. A start while irq_block is high is ignored.
- R9: A start while busy is high is ignored. It changes neither the memory traffic nor the results of the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Exception accepted strobe |
| exc_num | input | EXC_W | Exception number, indexes the vector table |
| user_en | input | 1 | 1: set main mask only; 0: set main and user mask |
| pc_in | input | ADDR_W | Program counter to save |
| ccr_in | input | CCR_W | Condition code byte to save |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | ADDR_W | Write data |
| mem_rdata | input | ADDR_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| pc_out | output | ADDR_W | Handler / start address |
| ccr_out | output | CCR_W | Condition code with updated mask bits |
| sp_out | output | ADDR_W | Current stack pointer |
| done | output | 1 | One-cycle pulse when pc_out is loaded |
| busy | output | 1 | Sequence in progress |
| irq_block | output | 1 | All interrupts including non-maskable are blocked |

## Verification
The in-RTL assertions check four things on every cycle. The handshake holds its values while ready is low. done never lasts two cycles and never occurs with busy high. The main mask bit is set whenever done fires. No write happens while interrupts are blocked, which covers the stack-free reset path. The bench scenarios show what a property cannot see: the exact addresses and data of both stack writes and their order, the handler address taken from the table, and the difference in mask bits between the two user_en settings. They also show the exact length of the post-reset block window and that stray starts leave no trace. The bench sweeps every exception number against both user_en values under several memory wait lengths.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
   typedef enum logic [2:0] {
      ST_RSTVEC   = 3'd0,
      ST_IDLE     = 3'd1,
      ST_PUSH_PC  = 3'd2,
      ST_PUSH_CCR = 3'd3,
      ST_FETCH    = 3'd4
   } seq_state_t;
endpackage

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
   import exc_seq_pkg::*;
#(
   parameter int unsigned HOLD_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       mem_ready,
   output seq_state_t state_o,
   output logic       mem_req_o,
   output logic       xfer_o,
   output logic       accept_o,
   output logic       done_o,
   output logic       irq_block_o
);
   localparam int unsigned CNT_W = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
   localparam logic [CNT_W-1:0] HOLD_INIT = CNT_W'(HOLD_CYC);

   seq_state_t       state_q, state_d;
   logic             rst_phase_q;
   logic [CNT_W-1:0] hold_q;
   logic             done_q;
   logic             last_step;

   assign mem_req_o   = rst_n && (state_q != ST_IDLE);
   assign xfer_o      = mem_req_o && mem_ready;
   assign irq_block_o = rst_phase_q || (hold_q != '0);
   assign accept_o    = (state_q == ST_IDLE) && start && !irq_block_o;
   assign last_step   = xfer_o && ((state_q == ST_FETCH) || (state_q == ST_RSTVEC));
   assign state_o     = state_q;
   assign done_o      = done_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (accept_o) state_d = ST_PUSH_PC;
         ST_PUSH_PC:  if (xfer_o)   state_d = ST_PUSH_CCR;
         ST_PUSH_CCR: if (xfer_o)   state_d = ST_FETCH;
         ST_FETCH:    if (xfer_o)   state_d = ST_IDLE;
         ST_RSTVEC:   if (xfer_o)   state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RSTVEC;
         rst_phase_q <= 1'b1;
         hold_q      <= HOLD_INIT;
         done_q      <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= last_step;
         if ((state_q == ST_RSTVEC) && xfer_o) begin
            rst_phase_q <= 1'b0;
         end
         if (!rst_phase_q && (hold_q != '0)) begin
            hold_q <= hold_q - 1'b1;
         end
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R6

   AST_STARTUP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RSTVEC) |-> irq_block_o); // R8
endmodule

// File: rtl/exc_sp_reg.sv
module exc_sp_reg #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned STEP    = 2,
   parameter int unsigned SP_INIT = 'h100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec,
   output logic [ADDR_W-1:0] sp_o,
   output logic [ADDR_W-1:0] sp_next_o
);
   localparam logic [ADDR_W-1:0] SP_RST  = ADDR_W'(SP_INIT);
   localparam logic [ADDR_W-1:0] SP_STEP = ADDR_W'(STEP);

   if (STEP == 0) begin : g_bad_step
      $error("exc_sp_reg: STEP must be nonzero");
   end

   logic [ADDR_W-1:0] sp_q;

   assign sp_o      = sp_q;
   assign sp_next_o = sp_q - SP_STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= SP_RST;
      end else if (dec) begin
         sp_q <= sp_next_o;
      end
   end
endmodule

// File: rtl/exc_mask_unit.sv
module exc_mask_unit #(
   parameter int unsigned CCR_W  = 8,
   parameter int unsigned I_BIT  = 7,
   parameter int unsigned UI_BIT = 6
) (
   input  logic [CCR_W-1:0] ccr_i,
   input  logic             user_en_i,
   output logic [CCR_W-1:0] ccr_o
);
   localparam logic [CCR_W-1:0] I_MASK  = CCR_W'(1) << I_BIT;
   localparam logic [CCR_W-1:0] UI_MASK = CCR_W'(1) << UI_BIT;

   if (I_BIT >= CCR_W || UI_BIT >= CCR_W) begin : g_bad_pos
      $error("exc_mask_unit: mask bit outside condition code");
   end
   if (I_BIT == UI_BIT) begin : g_bad_same
      $error("exc_mask_unit: mask bits must differ");
   end

   always_comb begin
      ccr_o = ccr_i | I_MASK;
      if (!user_en_i) begin
         ccr_o = ccr_o | UI_MASK;
      end
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned CCR_W       = 8,
   parameter int unsigned EXC_W       = 3,
   parameter int unsigned VEC_BYTES   = 2,
   parameter int unsigned I_BIT       = 7,
   parameter int unsigned UI_BIT      = 6,
   parameter int unsigned SP_INIT     = 'h100,
   parameter int unsigned HOLD_CYC    = 2,
   parameter int unsigned RST_VEC_NUM = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [EXC_W-1:0]  exc_num,
   input  logic              user_en,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [CCR_W-1:0]  ccr_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] pc_out,
   output logic [CCR_W-1:0]  ccr_out,
   output logic [ADDR_W-1:0] sp_out,
   output logic              done,
   output logic              busy,
   output logic              irq_block
);
   localparam int unsigned STEP   = ADDR_W / 8;
   localparam int unsigned VEC_SH = (VEC_BYTES < 2) ? 0 : $clog2(VEC_BYTES);
   localparam logic [CCR_W-1:0] CCR_RST = CCR_W'(1) << I_BIT;
   localparam logic [EXC_W-1:0] RST_NUM = EXC_W'(RST_VEC_NUM);

   if (ADDR_W < 8 || (ADDR_W % 8) != 0) begin : g_bad_addr
      $error("exc_entry_seq: ADDR_W must be a multiple of 8");
   end
   if (CCR_W > ADDR_W) begin : g_bad_ccr
      $error("exc_entry_seq: CCR_W wider than a stack word");
   end
   if (VEC_BYTES == 0) begin : g_bad_vec
      $error("exc_entry_seq: VEC_BYTES must be nonzero");
   end
   if (EXC_W + VEC_SH > ADDR_W) begin : g_bad_tbl
      $error("exc_entry_seq: vector table exceeds address space");
   end
   if (RST_VEC_NUM >= (1 << EXC_W)) begin : g_bad_rst
      $error("exc_entry_seq: reset vector number out of range");
   end

   seq_state_t        state;
   logic              xfer, accept;
   logic              sp_dec;
   logic [ADDR_W-1:0] sp_next;
   logic [EXC_W-1:0]  lat_num;
   logic [ADDR_W-1:0] lat_pc;
   logic [CCR_W-1:0]  lat_ccr;
   logic              lat_ue;
   logic [EXC_W-1:0]  fetch_num;
   logic [ADDR_W-1:0] vec_addr;
   logic [ADDR_W-1:0] ccr_word;
   logic [CCR_W-1:0]  ccr_masked;

   exc_seq_fsm #(
      .HOLD_CYC (HOLD_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mem_ready   (mem_ready),
      .state_o     (state),
      .mem_req_o   (mem_req),
      .xfer_o      (xfer),
      .accept_o    (accept),
      .done_o      (done),
      .irq_block_o (irq_block)
   );

   assign sp_dec = xfer && ((state == ST_PUSH_PC) || (state == ST_PUSH_CCR));

   exc_sp_reg #(
      .ADDR_W  (ADDR_W),
      .STEP    (STEP),
      .SP_INIT (SP_INIT)
   ) u_sp (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec       (sp_dec),
      .sp_o      (sp_out),
      .sp_next_o (sp_next)
   );

   exc_mask_unit #(
      .CCR_W  (CCR_W),
      .I_BIT  (I_BIT),
      .UI_BIT (UI_BIT)
   ) u_mask (
      .ccr_i     (lat_ccr),
      .user_en_i (lat_ue),
      .ccr_o     (ccr_masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_num <= '0;
         lat_pc  <= '0;
         lat_ccr <= '0;
         lat_ue  <= 1'b0;
      end else if (accept) begin
         lat_num <= exc_num;
         lat_pc  <= pc_in;
         lat_ccr <= ccr_in;
         lat_ue  <= user_en;
      end
   end

   assign fetch_num = (state == ST_RSTVEC) ? RST_NUM : lat_num;

   if ((1 << VEC_SH) == VEC_BYTES) begin : g_vec_shift
      assign vec_addr = ADDR_W'(fetch_num) << VEC_SH;
   end else begin : g_vec_mul
      assign vec_addr = ADDR_W'(fetch_num) * ADDR_W'(VEC_BYTES);
   end

   if (CCR_W == ADDR_W) begin : g_ccr_full
      assign ccr_word = lat_ccr;
   end else begin : g_ccr_ext
      assign ccr_word = {{(ADDR_W - CCR_W){1'b0}}, lat_ccr};
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_addr  = vec_addr;
      mem_wdata = '0;
      unique case (state)
         ST_PUSH_PC: begin
            mem_we    = 1'b1;
            mem_addr  = sp_next;
            mem_wdata = lat_pc;
         end
         ST_PUSH_CCR: begin
            mem_we    = 1'b1;
            mem_addr  = sp_next;
            mem_wdata = ccr_word;
         end
         default: begin
            mem_we    = 1'b0;
            mem_addr  = vec_addr;
            mem_wdata = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_out  <= '0;
         ccr_out <= CCR_RST;
      end else begin
         if (xfer && ((state == ST_FETCH) || (state == ST_RSTVEC))) begin
            pc_out <= mem_rdata;
         end
         if (xfer && (state == ST_PUSH_CCR)) begin
            ccr_out <= ccr_masked;
         end
      end
   end

   assign busy = (state != ST_IDLE);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R5

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6

   AST_MASK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ccr_out[I_BIT]); // R2

   AST_NO_PUSH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_block |-> !mem_we); // R7
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  exc_num = '0;
   logic        user_en = 1'b0;
   logic [15:0] pc_in = '0;
   logic [7:0]  ccr_in = '0;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr, mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic [15:0] pc_out, sp_out;
   logic [7:0]  ccr_out;
   logic        done, busy, irq_block;

   int n_cmp = 0;
   int n_bad = 0;
   int lat = 0;
   int wcnt = 0;
   int wcount = 0;
   logic [15:0] mem [0:255];
   logic [15:0] wl_addr [0:3];
   logic [15:0] wl_data [0:3];

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .exc_num(exc_num),
      .user_en(user_en), .pc_in(pc_in), .ccr_in(ccr_in),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .pc_out(pc_out), .ccr_out(ccr_out), .sp_out(sp_out),
      .done(done), .busy(busy), .irq_block(irq_block)
   );

   function automatic logic [15:0] vec_val(int n);
      return 16'h1000 + 16'(n) * 16'h0111;
   endfunction

   // memory model: answers after lat wait cycles, updates at negedge
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         wcnt <= 0;
      end else if (mem_ready) begin
         mem_ready <= 1'b0;
         wcnt <= 0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            mem_ready <= 1'b1;
            mem_rdata <= mem[mem_addr[8:1]];
            if (mem_we) begin
               mem[mem_addr[8:1]] <= mem_wdata;
               wl_addr[wcount % 4] <= mem_addr;
               wl_data[wcount % 4] <= mem_wdata;
               wcount <= wcount + 1;
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_done();
      int cyc = 0;
      while (!done && cyc < 300) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic run_exc(int num, bit ue, logic [15:0] pc, logic [7:0] ccr, int lt, bit stray);
      int base;
      logic [15:0] sp0;
      logic [7:0] exp_ccr;
      @(negedge clk);
      lat = lt;
      base = wcount;
      sp0 = sp_out;
      exc_num = 3'(num);
      user_en = ue;
      pc_in = pc;
      ccr_in = ccr;
      start = 1'b1;
      @(negedge clk);
      if (stray) begin
         // R9: extra starts while busy with different inputs
         exc_num = 3'(num ^ 1);
         user_en = ~ue;
         pc_in = ~pc;
         ccr_in = ~ccr;
         @(negedge clk);
         @(negedge clk);
      end
      start = 1'b0;
      wait_done();
      exp_ccr = ccr | 8'h80 | (ue ? 8'h00 : 8'h40);
      check("R6 done", 32'(done), 1);
      check("R6 busy", 32'(busy), 0);
      check("R4 pc_out", 32'(pc_out), 32'(vec_val(num)));
      if (ue) check("R2 ccr_out", 32'(ccr_out), 32'(exp_ccr));
      else    check("R3 ccr_out", 32'(ccr_out), 32'(exp_ccr));
      check("R1 writes", 32'(wcount - base), 2);
      check("R1 pc addr", 32'(wl_addr[base % 4]), 32'(sp0 - 16'd2));
      check("R1 pc data", 32'(wl_data[base % 4]), 32'(pc));
      check("R1 ccr addr", 32'(wl_addr[(base + 1) % 4]), 32'(sp0 - 16'd4));
      check("R1 ccr data", 32'(wl_data[(base + 1) % 4]), 32'({8'h00, ccr}));
      check("R1 sp_out", 32'(sp_out), 32'(sp0 - 16'd4));
      @(negedge clk);
      check("R6 pulse", 32'(done), 0);
      if (stray) check("R9 no extra", 32'(wcount - base), 2);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
      for (int n = 0; n < 8; n++) mem[n] = vec_val(n);
      for (int i = 0; i < 4; i++) begin
         wl_addr[i] = '0;
         wl_data[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R7 / R8: reset state
      check("R8 block in reset", 32'(irq_block), 1);
      check("R7 sp reset", 32'(sp_out), 32'h100);
      check("R7 ccr reset", 32'(ccr_out), 32'h80);
      check("R7 req in reset", 32'(mem_req), 0);
      check("R7 done in reset", 32'(done), 0);
      lat = 1;
      rst_n = 1'b1;
      start = 1'b1;
      exc_num = 3'd5;
      @(negedge clk);
      check("R8 block in startup", 32'(irq_block), 1);
      wait_done();
      check("R7 start pc", 32'(pc_out), 32'(vec_val(0)));
      check("R7 no writes", 32'(wcount), 0);
      check("R8 block done cycle", 32'(irq_block), 1);
      @(negedge clk);
      check("R8 block hold", 32'(irq_block), 1);
      @(negedge clk);
      check("R8 block released", 32'(irq_block), 0);
      start = 1'b0;
      @(negedge clk);
      check("R8 start ignored busy", 32'(busy), 0);
      check("R8 start ignored writes", 32'(wcount), 0);
      check("R8 start ignored sp", 32'(sp_out), 32'h100);
      check("R7 ccr after startup", 32'(ccr_out), 32'h80);
      // sweep: every exception number, both mask modes, varied waits
      for (int n = 0; n < 8; n++) begin
         for (int u = 0; u < 2; u++) begin
            run_exc(n, bit'(u), 16'h2000 + 16'(n * 'h37 + u),
                    8'((n * 8'h2B) ^ (u * 8'h44)), (n + u) % 4, 1'b0);
         end
      end
      run_exc(3, 1'b1, 16'hBEEF, 8'h41, 2, 1'b1);
      run_exc(6, 1'b0, 16'h1234, 8'hFF, 0, 1'b1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule